// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block runs one asynchronous access on an external bus whose address and data share the same 16 lines. It handles a single chip select. A host offers a request on a valid/ready port that carries direction, address and write data. Once the request is taken, the block counts clock ticks from the start of the access. Every control pin changes at a tick offset set on a configuration input:

- chip select assert and release
- end of the address-valid phase
- start and end of the read/write strobe
- read sample point
- access length

During the first phase of the access the address is driven onto the shared lines. For a write, the write data follows on the same lines. For a read, the master stops driving the lines, samples the external device at the chosen tick, and returns the sampled word to the host when the access ends. The block never waits on the external device, so the programmed values alone set the length of every access. An idle gap separates accesses that follow each other.

A typical setting for a slow external device:

| Setting | Tick |
|---|---|
| Chip select on | 0 |
| Chip select off | 7 |
| Address phase ends | 1 |
| Strobe on | 2 |
| Strobe off | 6 |
| Read sample | 6 |
| Access length | 8 |

The configuration inputs must stay stable while an access is in progress.

Top module: `muxBusMaster`

## Requirements
- R1: After reset, csN, advN, weN and oeN are high, adOe is 0, reqReady is 1, rspValid is 0 and rspData is 0.
- R2: A request is accepted on a clock edge where reqValid and reqReady are both 1. Tick 0 is the clock period that follows that edge. The access lasts max(cfgCycLen,1) ticks, and reqReady is 0 for all of those ticks.
- R3: In tick t of an access, csN is low exactly when cfgCsOn <= t < cfgCsOff.
- R4: In tick t of an access, advN is low exactly when t < cfgAdvOff.
- R5: In a write access (reqWrite=1), weN is low exactly when cfgStrbOn <= t < cfgStrbOff, and oeN stays high.
- R6: In a read access (reqWrite=0), oeN is low exactly when cfgStrbOn <= t < cfgStrbOff, and weN stays high.
- R7: In a write access, adOe is 1 in every tick. adOut carries the request address while t < cfgAdvOff and the write data after that.
- R8: In a read access, adOe is 1 and adOut carries the address while t < cfgAdvOff. After that adOe is 0, so the lines are released.
- R9: In a read, the value on adIn at the clock edge that ends tick cfgCapTick goes to rspData. If cfgCapTick is not below the access length, rspData keeps its previous value. rspValid is 1 for exactly the one clock after the last tick of a read, and it stays 0 after writes.
- R10: Outside an access all strobes are high and adOe is 0. After the last tick, reqReady stays 0 for IDLE_GAP-1 clocks. With reqValid held high, consecutive accepts are therefore exactly max(cfgCycLen,1)+IDLE_GAP clocks apart.
- R11: A strobe whose off tick is not greater than its on tick stays high for the whole access. This applies to chip select, the read/write strobe, and address-valid with cfgAdvOff=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Master can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Address for the address phase |
| reqWdata | input | 16 | Data for a write |
| rspValid | output | 1 | One-clock pulse after a read completes |
| rspData | output | 16 | Sampled read word |
| cfgCsOn | input | 4 | Chip select assert tick |
| cfgCsOff | input | 4 | Chip select release tick |
| cfgAdvOff | input | 4 | Address-valid release tick (assert is tick 0) |
| cfgStrbOn | input | 4 | Write/read strobe assert tick |
| cfgStrbOff | input | 4 | Write/read strobe release tick |
| cfgCapTick | input | 4 | Read sample tick |
| cfgCycLen | input | 4 | Access length in ticks |
| csN | output | 1 | Chip select, active low |
| advN | output | 1 | Address valid, active low |
| weN | output | 1 | Write strobe, active low |
| oeN | output | 1 | Output enable, active low |
| adOut | output | 16 | Value driven onto the shared lines |
| adOe | output | 1 | 1 = master drives the shared lines |
| adIn | input | 16 | Value read back from the shared lines |

## Verification
The bench sweeps the access length, the on and off ticks and the sample tick over a dense grid in both directions. This includes off ticks equal to or below on ticks, and off ticks beyond the access length. Together these show whether each window bound is inclusive or exclusive and whether strobes are clipped at the end of the access.

During each read, adIn carries a value that encodes the tick number. A capture one tick early or late therefore shows up as a wrong word. Address and write data use distinct patterns, so the point where the lines switch from address to data can be located.

A run with reqValid held high measures the spacing between accepts, which exposes a missing or extra idle tick. The sweep also includes the typical setting from the table above.

// File: rtl/muxBusPkg.sv
package muxBusPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_GAP  = 2'd2
  } ctlState_t;

  // strobes handed from control to datapath, already aligned to the current tick
  typedef struct packed {
    logic active;
    logic cs;
    logic adv;
    logic we;
    logic oe;
    logic addrPhase;
    logic capture;
    logic done;
    logic isWrite;
  } busStrb_t;

endpackage

// File: rtl/muxBusCtrl.sv
module muxBusCtrl
  import muxBusPkg::*;
#(
  parameter int TICK_W   = 4,
  parameter int IDLE_GAP = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  output logic              reqReady,
  output logic              accept,
  input  logic [TICK_W-1:0] cfgCsOn,
  input  logic [TICK_W-1:0] cfgCsOff,
  input  logic [TICK_W-1:0] cfgAdvOff,
  input  logic [TICK_W-1:0] cfgStrbOn,
  input  logic [TICK_W-1:0] cfgStrbOff,
  input  logic [TICK_W-1:0] cfgCapTick,
  input  logic [TICK_W-1:0] cfgCycLen,
  output busStrb_t          strb
);

  localparam int GAP_W = (IDLE_GAP > 2) ? $clog2(IDLE_GAP) : 1;
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'((IDLE_GAP > 1) ? IDLE_GAP - 2 : 0);

  ctlState_t         state, nState;
  logic [TICK_W-1:0] tick, nTick;
  logic [GAP_W-1:0]  gapCnt, nGap;
  logic              isWrite, nWrite;
  busStrb_t          nStrb;

  function automatic logic inWin(input logic [TICK_W-1:0] t,
                                 input logic [TICK_W-1:0] on,
                                 input logic [TICK_W-1:0] off);
    return (off > on) && (t >= on) && (t < off);
  endfunction

  function automatic logic isLast(input logic [TICK_W-1:0] t,
                                  input logic [TICK_W-1:0] len);
    return ({1'b0, t} + (TICK_W+1)'(1)) >= {1'b0, len};
  endfunction

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqReady && reqValid;

  always_comb begin
    nState = state;
    nTick  = tick;
    nGap   = gapCnt;
    nWrite = isWrite;
    case (state)
      ST_IDLE: if (reqValid) begin
        nState = ST_BUSY;
        nTick  = '0;
        nWrite = reqWrite;
      end
      ST_BUSY: if (isLast(tick, cfgCycLen)) begin
        nTick = '0;
        if (IDLE_GAP > 1) begin
          nState = ST_GAP;
          nGap   = GAP_LOAD;
        end else begin
          nState = ST_IDLE;
        end
      end else begin
        nTick = tick + TICK_W'(1);
      end
      ST_GAP: if (gapCnt == '0) nState = ST_IDLE;
              else nGap = gapCnt - GAP_W'(1);
      default: nState = ST_IDLE;
    endcase
  end

  // decode the strobes for the tick that starts at the next edge
  always_comb begin
    logic busy;
    busy              = (nState == ST_BUSY);
    nStrb.active      = busy;
    nStrb.isWrite     = busy && nWrite;
    nStrb.cs          = busy && inWin(nTick, cfgCsOn, cfgCsOff);
    nStrb.adv         = busy && inWin(nTick, '0, cfgAdvOff);
    nStrb.addrPhase   = nStrb.adv;
    nStrb.we          = busy && nWrite && inWin(nTick, cfgStrbOn, cfgStrbOff);
    nStrb.oe          = busy && !nWrite && inWin(nTick, cfgStrbOn, cfgStrbOff);
    nStrb.capture     = busy && !nWrite && (nTick == cfgCapTick);
    nStrb.done        = busy && isLast(nTick, cfgCycLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tick    <= '0;
      gapCnt  <= '0;
      isWrite <= 1'b0;
      strb    <= '0;
    end else begin
      state   <= nState;
      tick    <= nTick;
      gapCnt  <= nGap;
      isWrite <= nWrite;
      strb    <= nStrb;
    end
  end

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (tick == '0) && strb.active); // R2
  AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |-> (({1'b0, tick} < {1'b0, cfgCycLen}) || (tick == '0))); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.we && strb.oe)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_BUSY) |=> !strb.active || $past(state == ST_IDLE)); // R10

endmodule

// File: rtl/muxBusDatapath.sv
module muxBusDatapath
  import muxBusPkg::*;
#(
  parameter int AD_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            accept,
  input  logic [AD_W-1:0] reqAddr,
  input  logic [AD_W-1:0] reqWdata,
  input  busStrb_t        strb,
  output logic            rspValid,
  output logic [AD_W-1:0] rspData,
  output logic            csN,
  output logic            advN,
  output logic            weN,
  output logic            oeN,
  output logic [AD_W-1:0] adOut,
  output logic            adOe,
  input  logic [AD_W-1:0] adIn
);

  logic [AD_W-1:0] addrQ, dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      dataQ    <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (accept) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
      end
      if (strb.capture) rspData <= adIn;
      rspValid <= strb.done && !strb.isWrite;
    end
  end

  assign csN  = ~strb.cs;
  assign advN = ~strb.adv;
  assign weN  = ~strb.we;
  assign oeN  = ~strb.oe;
  assign adOe = strb.active && (strb.isWrite || strb.addrPhase);

  always_comb begin
    if (!strb.active)        adOut = '0;
    else if (strb.addrPhase) adOut = addrQ;
    else if (strb.isWrite)   adOut = dataQ;
    else                     adOut = '0;
  end

  AST_RSP_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.capture) |-> $stable(rspData)); // R9

endmodule

// File: rtl/muxBusMaster.sv
module muxBusMaster
  import muxBusPkg::*;
#(
  parameter int AD_W     = 16,
  parameter int TICK_W   = 4,
  parameter int IDLE_GAP = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [AD_W-1:0]   reqAddr,
  input  logic [AD_W-1:0]   reqWdata,
  output logic              rspValid,
  output logic [AD_W-1:0]   rspData,
  input  logic [TICK_W-1:0] cfgCsOn,
  input  logic [TICK_W-1:0] cfgCsOff,
  input  logic [TICK_W-1:0] cfgAdvOff,
  input  logic [TICK_W-1:0] cfgStrbOn,
  input  logic [TICK_W-1:0] cfgStrbOff,
  input  logic [TICK_W-1:0] cfgCapTick,
  input  logic [TICK_W-1:0] cfgCycLen,
  output logic              csN,
  output logic              advN,
  output logic              weN,
  output logic              oeN,
  output logic [AD_W-1:0]   adOut,
  output logic              adOe,
  input  logic [AD_W-1:0]   adIn
);

  busStrb_t strb;
  logic     accept;

  muxBusCtrl #(.TICK_W(TICK_W), .IDLE_GAP(IDLE_GAP)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .accept(accept),
    .cfgCsOn(cfgCsOn), .cfgCsOff(cfgCsOff), .cfgAdvOff(cfgAdvOff),
    .cfgStrbOn(cfgStrbOn), .cfgStrbOff(cfgStrbOff),
    .cfgCapTick(cfgCapTick), .cfgCycLen(cfgCycLen), .strb(strb)
  );

  muxBusDatapath #(.AD_W(AD_W)) uData (
    .clk(clk), .rstN(rstN), .accept(accept),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .strb(strb),
    .rspValid(rspValid), .rspData(rspData),
    .csN(csN), .advN(advN), .weN(weN), .oeN(oeN),
    .adOut(adOut), .adOe(adOe), .adIn(adIn)
  );

  AST_READY_PINS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (csN && advN && weN && oeN && !adOe)); // R10
  AST_RELEASED_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (!oeN && advN) |-> !adOe); // R8

endmodule

// File: tb/muxBusMaster_test.sv
`timescale 1ns/1ps
module muxBusMaster_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0, adIn = '0;
  logic [3:0]  cfgCsOn = '0, cfgCsOff = '0, cfgAdvOff = '0, cfgStrbOn = '0;
  logic [3:0]  cfgStrbOff = '0, cfgCapTick = '0, cfgCycLen = '0;
  logic        reqReady, rspValid, csN, advN, weN, oeN, adOe;
  logic [15:0] rspData, adOut;

  int total = 0;
  int fails = 0;
  logic [15:0] expRsp = '0;

  always #2 clk = ~clk;

  muxBusMaster uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData),
    .cfgCsOn(cfgCsOn), .cfgCsOff(cfgCsOff), .cfgAdvOff(cfgAdvOff),
    .cfgStrbOn(cfgStrbOn), .cfgStrbOff(cfgStrbOff),
    .cfgCapTick(cfgCapTick), .cfgCycLen(cfgCycLen),
    .csN(csN), .advN(advN), .weN(weN), .oeN(oeN),
    .adOut(adOut), .adOe(adOe), .adIn(adIn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic win(input int t, input int on, input int off);
    return (off > on) && (t >= on) && (t < off);
  endfunction

  function automatic logic [15:0] pat(input int t);
    return 16'hC300 + 16'(t);
  endfunction

  // run one access and check every tick
  task automatic access(input logic wr, input logic [15:0] a, input logic [15:0] d,
                        input int csOn, input int csOff, input int advOff,
                        input int sOn, input int sOff, input int cap, input int len);
    int lenEff;
    logic got;
    lenEff = (len == 0) ? 1 : len;
    @(negedge clk);
    cfgCsOn = 4'(csOn); cfgCsOff = 4'(csOff); cfgAdvOff = 4'(advOff);
    cfgStrbOn = 4'(sOn); cfgStrbOff = 4'(sOff); cfgCapTick = 4'(cap);
    cfgCycLen = 4'(len);
    reqWrite = wr; reqAddr = a; reqWdata = d; reqValid = 1'b1;
    got = 1'b0;
    while (!got) begin
      got = reqReady;
      @(negedge clk);
    end
    reqValid = 1'b0;
    for (int k = 0; k < lenEff; k++) begin
      chk("R2 reqReady low in access", reqReady, 1'b0);
      chk("R3 csN", csN, !win(k, csOn, csOff));
      chk("R4 advN", advN, !win(k, 0, advOff));
      chk(wr ? "R5 weN" : "R6 weN", weN, !(wr && win(k, sOn, sOff)));
      chk(wr ? "R5 oeN" : "R6 oeN", oeN, !(!wr && win(k, sOn, sOff)));
      if (wr) begin
        chk("R7 adOe", adOe, 1'b1);
        chk("R7 adOut", adOut, (k < advOff) ? a : d);
      end else begin
        chk("R8 adOe", adOe, k < advOff);
        if (k < advOff) chk("R8 adOut", adOut, a);
      end
      adIn = pat(k);
      @(negedge clk);
    end
    if (!wr && cap < lenEff) expRsp = pat(cap);
    chk("R9 rspValid", rspValid, !wr);
    chk("R9 rspData", rspData, expRsp);
    chk("R10 pins idle", {csN, advN, weN, oeN, adOe}, 5'b11110);
    chk("R10 ready after gap", reqReady, 1'b1);
    adIn = 16'h0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 strobes", {csN, advN, weN, oeN}, 4'hF);
    chk("R1 adOe", adOe, 1'b0);
    chk("R1 reqReady", reqReady, 1'b1);
    chk("R1 rsp", {rspValid, rspData}, 17'h0);
    rstN = 1'b1;
    @(negedge clk);

    // typical setting, write then read
    access(1'b1, 16'h1234, 16'hBEEF, 0, 7, 1, 2, 6, 6, 8);
    access(1'b0, 16'h4321, 16'h0000, 0, 7, 1, 2, 6, 6, 8);

    // dense sweep, includes illegal windows (R11) and capture past the end
    for (int len = 0; len <= 9; len++)
      for (int on = 0; on <= 4; on++)
        for (int off = 0; off <= 9; off++)
          for (int w = 0; w < 2; w++)
            access(w[0], 16'(16'hA000 + on*16 + off), 16'(16'h5000 + len*256 + off),
                   on, off, (on + off + w) % 5, (off + 1) % 5, (on * 3 + len) % 7,
                   (on + off) % 11, len);

    // R11 explicit: all off ticks at or below on ticks
    access(1'b1, 16'h7777, 16'h8888, 3, 3, 0, 5, 2, 0, 6);
    access(1'b0, 16'h6666, 16'h0, 4, 1, 0, 2, 2, 3, 6);

    // R10 back-to-back spacing with reqValid held high
    begin
      int cyc, firstAcc, secondAcc, nAcc;
      @(negedge clk);
      cfgCsOn = 0; cfgCsOff = 3; cfgAdvOff = 1; cfgStrbOn = 1; cfgStrbOff = 3;
      cfgCapTick = 2; cfgCycLen = 4'd5; reqWrite = 1'b1; reqValid = 1'b1;
      cyc = 0; nAcc = 0; firstAcc = 0; secondAcc = 0;
      while (nAcc < 2) begin
        if (reqReady) begin
          if (nAcc == 0) firstAcc = cyc; else secondAcc = cyc;
          nAcc++;
        end
        @(negedge clk);
        cyc++;
      end
      reqValid = 1'b0;
      chk("R10 accept spacing", 32'(secondAcc - firstAcc), 32'd6);
      repeat (8) @(negedge clk);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule